// File: doc/BRIEF.md
# Sampling Tap Drift Corrector

This block keeps the receive sampling point of a high-speed card interface centred after the initial tuning sweep. It holds the active tap, a logical index in 0..TAP_NUM-1. The sampling-compare logic reports drift as request pulses (step down, step up, error), and the block gathers them in a small sticky register. On each check strobe it moves the tap by one position, wrapping modulo TAP_NUM, leaves the tap as it is, or raises a one-cycle retune request. Which inputs drive that decision depends on the timing mode and on whether automatic correction is on.

Software loads the tap chosen by tuning through a load port. A separate strobe marks entry into HS400 mode, and at that point the block steers the tap off any position flagged in the bad-tap mask. In HS400, data is sampled against a strobe returned by the card, so only the command-line compare result steers the tap, and a step into a bad tap is refused. When taps are used in pairs ("four-tap" operation), the value presented to the tap register is the logical tap halved.

Top module: `tap_corrector`

## Requirements
- R1: After reset the logical tap is 0, the retune pulse is low and the request register is empty.
- R2: Request pulses are ORed into a sticky register (bit 0 step down, bit 1 step up, bit 2 error). Every performed check empties it. A pulse arriving in the same cycle as a performed check is kept for the next check.
- R3: Outside HS400 with manual correction, a performed check picks in priority order: error raises retune and keeps the tap, then step up gives tap+1 mod TAP_NUM, then step down gives tap-1 mod TAP_NUM, and an empty register changes nothing.
- R4: In HS400 with manual correction, a performed check acts only when the request register is non-empty, and then reads only the command compare input (bit 1 up, bit 0 down). Up alone steps +1, down alone steps -1 (both mod TAP_NUM), both set raises retune, neither set does nothing.
- R5: In HS400, if the step target is set in the bad-tap mask, the tap stays unchanged and retune is raised only when the current tap's bit in the sweep-pass vector is 1.
- R6: With automatic correction enabled, a performed check looks only at the error bit: error raises retune, and step requests never move the tap.
- R7: A strobe is skipped, leaving tap, retune and request register as they were, when the mode is 0 (other), when the mode is 3 (HS400) with four-tap set, or while tuning is in progress. Mode codes: 0 other, 1 SDR104, 2 HS200, 3 HS400.
- R8: A load sets the tap to the given value (below TAP_NUM). Load beats HS400 entry, and entry beats a check. A strobe that coincides with either is not performed.
- R9: On HS400 entry, a tap that is not bad is kept. A bad tap tries tap+1, then tap-1 (mod TAP_NUM). If both are also bad, the tap is kept.
- R10: The tap register output equals the logical tap, or the logical tap shifted right by one when four-tap is set.
- R11: Retune is a one-cycle pulse in the cycle after the performed check that caused it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| chk_stb_i | input | 1 | Check strobe |
| req_set_i | input | 3 | Request pulses: 0 down, 1 up, 2 error |
| cmd_cmp_i | input | 2 | Command compare status: 1 up, 0 down |
| mode_i | input | 2 | Timing mode code |
| four_tap_i | input | 1 | Paired-tap operation |
| tuning_i | input | 1 | Tuning sweep in progress |
| auto_en_i | input | 1 | Automatic correction enabled |
| bad_mask_i | input | TAP_NUM | Taps unusable in HS400 |
| sweep_ok_i | input | TAP_NUM | Sample-compare pass per tap from the sweep |
| load_i | input | 1 | Load tuned tap |
| load_tap_i | input | TW | Tap value to load |
| hs400_go_i | input | 1 | HS400 entry strobe |
| tap_cur_o | output | TW | Logical tap |
| tap_reg_o | output | TW | Value for the tap register |
| retune_o | output | 1 | Retune request pulse |

## Verification
Two functions can act on the request register in the same cycle: a new request pulse can arrive just as a performed check empties it. The bench drives request pulses and strobes independently, so this collision comes up many times. Its reference model clears the register first and then ORs in the new bits, and the next check must act on what survived. Strobes that coincide with loads and HS400 entry are judged against the stated priority by comparing tap and retune on every clock.

// File: rtl/tapc_pkg.sv
package tapc_pkg;
   typedef enum logic [1:0] {
      TM_OTHER  = 2'd0,
      TM_SDR104 = 2'd1,
      TM_HS200  = 2'd2,
      TM_HS400  = 2'd3
   } tmode_e;

   localparam int REQ_DN  = 0;
   localparam int REQ_UP  = 1;
   localparam int REQ_ERR = 2;
   localparam int REQ_W   = 3;
   localparam int CMP_DN  = 0;
   localparam int CMP_UP  = 1;
endpackage

// File: rtl/tapc_wrap.sv
module tapc_wrap #(
   parameter int TAP_NUM = 8,
   localparam int TW = $clog2(TAP_NUM)
) (
   input  logic [TW-1:0] tap_i,
   output logic [TW-1:0] inc_o,
   output logic [TW-1:0] dec_o
);
   localparam int POW2 = ((1 << TW) == TAP_NUM) ? 1 : 0;

   generate
      if (POW2 == 1) begin : g_pow2
         assign inc_o = tap_i + 1'b1;
         assign dec_o = tap_i - 1'b1;
      end else begin : g_cmp
         assign inc_o = (tap_i == TW'(TAP_NUM - 1)) ? '0 : tap_i + 1'b1;
         assign dec_o = (tap_i == '0) ? TW'(TAP_NUM - 1) : tap_i - 1'b1;
      end
   endgenerate
endmodule

// File: rtl/tapc_reqreg.sv
module tapc_reqreg
   import tapc_pkg::*;
(
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [REQ_W-1:0] set_i,
   input  logic             clr_i,
   output logic [REQ_W-1:0] req_o
);
   logic [REQ_W-1:0] req_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) req_q <= '0;
      else         req_q <= (clr_i ? '0 : req_q) | set_i;
   end

   assign req_o = req_q;

   assert_clear_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i && set_i == '0) |=> (req_o == '0));
   assert_sticky_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !clr_i |=> ((req_o & $past(req_o)) == $past(req_o)));
endmodule

// File: rtl/tapc_decide.sv
module tapc_decide
   import tapc_pkg::*;
#(
   parameter int TAP_NUM = 8,
   localparam int TW = $clog2(TAP_NUM)
) (
   input  logic [TW-1:0]      tap_i,
   input  logic [TW-1:0]      inc_i,
   input  logic [TW-1:0]      dec_i,
   input  logic [REQ_W-1:0]   req_i,
   input  logic [1:0]         cmd_cmp_i,
   input  tmode_e             mode_i,
   input  logic               auto_en_i,
   input  logic [TAP_NUM-1:0] bad_mask_i,
   input  logic [TAP_NUM-1:0] sweep_ok_i,
   output logic               move_o,
   output logic [TW-1:0]      nxt_o,
   output logic               retune_o
);
   logic          want;
   logic [TW-1:0] cand;

   always_comb begin
      move_o   = 1'b0;
      nxt_o    = tap_i;
      retune_o = 1'b0;
      want     = 1'b0;
      cand     = tap_i;
      if (auto_en_i) begin
         retune_o = req_i[REQ_ERR];
      end else if (mode_i == TM_HS400) begin
         if (req_i != '0) begin
            unique case (cmd_cmp_i)
               2'b10:   begin want = 1'b1; cand = inc_i; end
               2'b01:   begin want = 1'b1; cand = dec_i; end
               2'b11:   retune_o = 1'b1;
               default: ;
            endcase
         end
         if (want) begin
            if (bad_mask_i[cand]) begin
               retune_o = sweep_ok_i[tap_i];
            end else begin
               move_o = 1'b1;
               nxt_o  = cand;
            end
         end
      end else begin
         if (req_i[REQ_ERR]) begin
            retune_o = 1'b1;
         end else if (req_i[REQ_UP]) begin
            move_o = 1'b1;
            nxt_o  = inc_i;
         end else if (req_i[REQ_DN]) begin
            move_o = 1'b1;
            nxt_o  = dec_i;
         end
      end
   end
endmodule

// File: rtl/tapc_avoid.sv
module tapc_avoid #(
   parameter int TAP_NUM = 8,
   localparam int TW = $clog2(TAP_NUM)
) (
   input  logic [TW-1:0]      tap_i,
   input  logic [TW-1:0]      inc_i,
   input  logic [TW-1:0]      dec_i,
   input  logic [TAP_NUM-1:0] bad_mask_i,
   output logic [TW-1:0]      tgt_o
);
   always_comb begin
      if (!bad_mask_i[tap_i])     tgt_o = tap_i;
      else if (!bad_mask_i[inc_i]) tgt_o = inc_i;
      else if (!bad_mask_i[dec_i]) tgt_o = dec_i;
      else                         tgt_o = tap_i;
   end
endmodule

// File: rtl/tap_corrector.sv
module tap_corrector
   import tapc_pkg::*;
#(
   parameter int TAP_NUM = 8,
   localparam int TW = $clog2(TAP_NUM)
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               chk_stb_i,
   input  logic [2:0]         req_set_i,
   input  logic [1:0]         cmd_cmp_i,
   input  logic [1:0]         mode_i,
   input  logic               four_tap_i,
   input  logic               tuning_i,
   input  logic               auto_en_i,
   input  logic [TAP_NUM-1:0] bad_mask_i,
   input  logic [TAP_NUM-1:0] sweep_ok_i,
   input  logic               load_i,
   input  logic [TW-1:0]      load_tap_i,
   input  logic               hs400_go_i,
   output logic [TW-1:0]      tap_cur_o,
   output logic [TW-1:0]      tap_reg_o,
   output logic               retune_o
);
   initial begin
      assert (TAP_NUM >= 2 && TAP_NUM <= 64 && (TAP_NUM % 2) == 0)
         else $error("TAP_NUM must be even and within 2..64");
   end

   tmode_e           mode;
   logic [TW-1:0]    tap_q;
   logic [TW-1:0]    tap_inc, tap_dec, avoid_tgt, dec_nxt;
   logic [REQ_W-1:0] req;
   logic             eligible, perform, dec_move, dec_retune, retune_q;

   assign mode     = tmode_e'(mode_i);
   assign eligible = (mode != TM_OTHER) && !(mode == TM_HS400 && four_tap_i) && !tuning_i;
   assign perform  = chk_stb_i && !load_i && !hs400_go_i && eligible;

   tapc_wrap #(.TAP_NUM(TAP_NUM)) i_wrap (
      .tap_i (tap_q),
      .inc_o (tap_inc),
      .dec_o (tap_dec)
   );

   tapc_reqreg i_req (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (req_set_i),
      .clr_i  (perform),
      .req_o  (req)
   );

   tapc_decide #(.TAP_NUM(TAP_NUM)) i_decide (
      .tap_i      (tap_q),
      .inc_i      (tap_inc),
      .dec_i      (tap_dec),
      .req_i      (req),
      .cmd_cmp_i  (cmd_cmp_i),
      .mode_i     (mode),
      .auto_en_i  (auto_en_i),
      .bad_mask_i (bad_mask_i),
      .sweep_ok_i (sweep_ok_i),
      .move_o     (dec_move),
      .nxt_o      (dec_nxt),
      .retune_o   (dec_retune)
   );

   tapc_avoid #(.TAP_NUM(TAP_NUM)) i_avoid (
      .tap_i      (tap_q),
      .inc_i      (tap_inc),
      .dec_i      (tap_dec),
      .bad_mask_i (bad_mask_i),
      .tgt_o      (avoid_tgt)
   );

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         tap_q    <= '0;
         retune_q <= 1'b0;
      end else begin
         if (load_i)                    tap_q <= load_tap_i;
         else if (hs400_go_i)           tap_q <= avoid_tgt;
         else if (perform && dec_move)  tap_q <= dec_nxt;
         retune_q <= perform && dec_retune;
      end
   end

   assign tap_cur_o = tap_q;
   assign tap_reg_o = four_tap_i ? (tap_q >> 1) : tap_q;
   assign retune_o  = retune_q;

   assert_tap_range_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tap_cur_o < TW'(TAP_NUM - 1) || tap_cur_o == TW'(TAP_NUM - 1));
   assert_skip_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (chk_stb_i && !eligible && !load_i && !hs400_go_i) |=> (!retune_o && $stable(tap_q)));
   assert_retune_cause_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      retune_o |-> $past(chk_stb_i));
   assert_single_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (perform && dec_move) |=> (tap_q == $past(tap_inc) || tap_q == $past(tap_dec)));
   assert_no_bad_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (perform && dec_move && mode == TM_HS400) |-> !bad_mask_i[dec_nxt]);
   assert_entry_clean_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (hs400_go_i && !load_i) |-> (avoid_tgt == tap_q || !bad_mask_i[avoid_tgt]));
endmodule

// File: tb/test_tap_corrector.sv
module test_tap_corrector;
   localparam int N  = 8;
   localparam int TW = $clog2(N);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          chk = 1'b0;
   logic [2:0]    req_set = '0;
   logic [1:0]    cmd = '0;
   logic [1:0]    mode = 2'd1;
   logic          four = 1'b0, tuning = 1'b0, auto_en = 1'b0;
   logic [N-1:0]  bad = '0, swok = '0;
   logic          load = 1'b0, go = 1'b0;
   logic [TW-1:0] ld_tap = '0;
   logic [TW-1:0] tap_cur, tap_reg;
   logic          retune;

   int n_chk = 0, n_fail = 0;
   int m_tap = 0, m_rt = 0, m_req = 0;
   string why = "R1";

   always #10 clk = ~clk;

   tap_corrector #(.TAP_NUM(N)) i_tap_corrector (
      .clk_i(clk), .rst_ni(rst_n), .chk_stb_i(chk), .req_set_i(req_set),
      .cmd_cmp_i(cmd), .mode_i(mode), .four_tap_i(four), .tuning_i(tuning),
      .auto_en_i(auto_en), .bad_mask_i(bad), .sweep_ok_i(swok), .load_i(load),
      .load_tap_i(ld_tap), .hs400_go_i(go), .tap_cur_o(tap_cur),
      .tap_reg_o(tap_reg), .retune_o(retune)
   );

   // Behavioural reference model, evaluated on every rising edge.
   always @(posedge clk) begin
      int nt, c;
      bit perf, want;
      if (!rst_n) begin
         m_tap = 0; m_rt = 0; m_req = 0; why = "R1";
      end else begin
         m_rt = 0;
         why  = "R11";
         perf = chk && !load && !go && mode != 2'd0 &&
                !(mode == 2'd3 && four) && !tuning;
         if (load) begin
            m_tap = int'(ld_tap); why = "R8";
         end else if (go) begin
            c = m_tap;
            if (bad[m_tap]) begin
               c = (m_tap + 1) % N;
               if (bad[c]) c = (m_tap + N - 1) % N;
               if (bad[c]) c = m_tap;
            end
            m_tap = c; why = "R9";
         end else if (perf) begin
            if (auto_en) begin
               if (m_req[2]) m_rt = 1;
               why = "R6";
            end else if (mode == 2'd3) begin
               want = 0; nt = m_tap; why = "R4";
               if (m_req != 0) begin
                  if (cmd == 2'b10) begin want = 1; nt = (m_tap + 1) % N; end
                  else if (cmd == 2'b01) begin want = 1; nt = (m_tap + N - 1) % N; end
                  else if (cmd == 2'b11) m_rt = 1;
               end
               if (want) begin
                  if (bad[nt]) begin m_rt = int'(swok[m_tap]); why = "R5"; end
                  else m_tap = nt;
               end
            end else begin
               why = "R3";
               if (m_req[2]) m_rt = 1;
               else if (m_req[1]) m_tap = (m_tap + 1) % N;
               else if (m_req[0]) m_tap = (m_tap + N - 1) % N;
            end
            m_req = 0;
         end else if (chk) begin
            why = "R7";
         end
         if (req_set != 0 && perf) why = {why, "/R2"};
         m_req = m_req | int'(req_set);
      end
   end

   task automatic compare();
      int exp_reg;
      exp_reg = four ? m_tap / 2 : m_tap;
      n_chk++;
      if (int'(tap_cur) != m_tap || int'(retune) != m_rt || int'(tap_reg) != exp_reg) begin
         n_fail++;
         $display("FAIL %s(R10 reg): tap=%0d reg=%0d retune=%0d expected tap=%0d reg=%0d retune=%0d",
                  why, tap_cur, tap_reg, retune, m_tap, exp_reg, m_rt);
      end
   endtask

   task automatic idle();
      chk = 0; req_set = 0; load = 0; go = 0;
   endtask

   initial begin
      #2_000_000;
      n_fail++;
      $display("FAIL R11 watchdog: actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      compare();                        // R1 reset state
      rst_n = 1'b1;
      // Directed: R9 with all three neighbours bad keeps tap
      @(negedge clk); compare(); load = 1; ld_tap = 3'd3;
      @(negedge clk); compare(); idle(); bad = 8'b0001_1100; go = 1;
      @(negedge clk); compare(); idle(); bad = 8'b0000_1000; go = 1;  // R9 -> 4
      @(negedge clk); compare(); idle(); bad = 8'b0001_1000; load = 1; ld_tap = 3'd3;
      @(negedge clk); compare(); idle(); go = 1;                    // R9 -> 2
      // Directed: R5 refused step in HS400, R2 collision
      @(negedge clk); compare(); idle(); mode = 2'd3; bad = 8'b0000_0010;
      swok = 8'b0000_0100; load = 1; ld_tap = 3'd2; req_set = 3'b010;
      @(negedge clk); compare(); idle(); cmd = 2'b01; chk = 1; req_set = 3'b001;
      @(negedge clk); compare(); idle(); cmd = 2'b10; chk = 1;      // R2 survivor steps up
      @(negedge clk); compare(); idle(); mode = 2'd1; load = 1; ld_tap = 3'd0; req_set = 3'b001;
      @(negedge clk); compare(); idle(); chk = 1;                   // R3 wrap 0 -> 7
      @(negedge clk); compare(); idle();
      // Random phase
      for (int cyc = 0; cyc < 6000; cyc++) begin
         int r;
         @(negedge clk);
         compare();
         idle();
         r = int'($urandom % 100);
         load = (r < 3);
         go   = (r >= 3 && r < 8);
         ld_tap = TW'($urandom % N);
         chk  = ($urandom % 3) == 0;
         if (($urandom % 4) == 0) req_set = 3'($urandom % 8);
         cmd  = 2'($urandom % 4);
         if ((cyc % 40) == 0) begin
            mode    = 2'($urandom % 4);
            four    = ($urandom % 4) == 0;
            auto_en = ($urandom % 4) == 0;
            bad     = N'($urandom & $urandom);
            swok    = N'($urandom);
         end
         tuning = ($urandom % 16) == 0;
      end
      @(negedge clk); compare();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end
endmodule